// File: doc/BRIEF.md
# Processor Interrupt Recognition Front-End

This block sits on the processor side of the interrupt path. It decides, at each instruction boundary, whether an interrupt is taken and which one. Three sources compete. The first is a single-step trap raised while the trap flag is set. The second is a non-maskable request that is edge-qualified. The third is a maskable level request, gated by the interrupt-enable flag. When a source wins, the block produces its type number and the matching vector-table address. For the maskable request it first runs a one-cycle active-low acknowledge strobe. It then captures the 8-bit type number that an external controller places on the data bus.

The block owns the interrupt-enable and trap flags. Execution logic writes them through a load strobe. Recognition saves both flags on a small last-in-first-out store and clears them. A return-from-interrupt pulse restores the saved pair. Stack pushes to memory, vector fetch and instruction execution are left to the rest of the processor. The inputs are assumed to be synchronous to `clk`.

Top module: `intr_recog`

## Requirements
- R1: After reset, `inta_n` is 1, `vec_valid` is 0, and `if_q` and `tf_q` are both 0.
- R2: A cycle with `flag_ld` high writes `ld_if` and `ld_tf` into `if_q` and `tf_q`, which show the new values one clock later.
- R3: The non-maskable input is accepted on a rising edge only if it was sampled low for at least NMI_MIN_LOW consecutive clocks before that edge (default 2). An edge after a single low clock is discarded.
- R4: An accepted non-maskable request stays pending only while `nmi_in` stays high. If it falls before a boundary recognizes it, the request is dropped.
- R5: At a boundary the sources are ranked single-step first, then non-maskable, then maskable. Only the highest-ranked source is taken.
- R6: A boundary seen while the trap flag is 1 gives `vec_valid` in the next cycle, with type 1.
- R7: A boundary that finds a pending non-maskable request gives `vec_valid` in the next cycle, with type 2.
- R8: A maskable request taken at a boundary drives `inta_n` low for exactly the next cycle. `data_in` is captured at the clock edge where `inta_n` returns high, and `vec_valid` is 1 in that same cycle.
- R9: While the interrupt-enable flag is 0, `intr_in` has no effect: `inta_n` stays high.
- R10: `vec_addr` always equals `vec_type` multiplied by 4.
- R11: Recognition clears both flags. Each `iret` pulse restores the most recently saved pair, so nested recognitions unwind in reverse order. An `iret` with nothing saved leaves the flags unchanged.
- R12: When `iret` and `boundary` occur in the same cycle, the restored flags decide the recognition, and they are the values saved.
- R13: A boundary that arrives while an acknowledge is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge qualified |
| intr_in | input | 1 | Maskable request, level |
| boundary | input | 1 | One-cycle pulse at each instruction boundary |
| iret | input | 1 | One-cycle pulse when a return-from-interrupt completes |
| flag_ld | input | 1 | Load strobe for the two flags |
| ld_if | input | 1 | Interrupt-enable value to load |
| ld_tf | input | 1 | Trap value to load |
| data_in | input | VEC_W | Type number driven by the external controller |
| inta_n | output | 1 | Active-low acknowledge strobe |
| vec_valid | output | 1 | One-cycle pulse: type and address are valid |
| vec_type | output | VEC_W | Interrupt type number |
| vec_addr | output | VEC_W+2 | Vector-table address, type times 4 |
| if_q | output | 1 | Current interrupt-enable flag |
| tf_q | output | 1 | Current trap flag |

## Verification
The delicate collision is a return pulse landing on the same boundary as a recognition. The flag store must pop and push at once, and the restored enable flag must decide whether a maskable request is taken. The bench holds the maskable request inside a handler whose enable flag is 0. It then pulses `iret` and `boundary` together and expects the acknowledge strobe in the next cycle. A later `iret` must bring back the enable flag saved before the first handler. A second collision sends a boundary and a flag load into the acknowledge cycle. The bench judges this by checking that no second strobe follows.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic {ST_IDLE, ST_ACK} seq_st_t;
  localparam int unsigned TYPE_STEP = 1;
  localparam int unsigned TYPE_NMI  = 2;
endpackage

// File: rtl/intr_nmi_qual.sv
module intr_nmi_qual #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic nmi_taken,
  output logic nmi_pend
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic          prev_q, prev_d;
  logic [CW-1:0] low_q, low_d;
  logic          pend_q, pend_d;
  logic          edge_ok;

  // consecutive-low counter saturates at the limit
  always_comb begin
    prev_d  = nmi_in;
    low_d   = nmi_in ? '0 : ((low_q == LIM) ? low_q : low_q + 1'b1);
    edge_ok = nmi_in && !prev_q && (low_q >= LIM);
    pend_d  = pend_q;
    if (!nmi_in || nmi_taken) pend_d = 1'b0;
    else if (edge_ok)         pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      low_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      low_q  <= low_d;
      pend_q <= pend_d;
    end
  end

  assign nmi_pend = pend_q;
endmodule

// File: rtl/intr_flag_stack.sv
module intr_flag_stack #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic in_if,
  input  logic in_tf,
  output logic top_if,
  output logic top_tf,
  output logic empty
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0]    sp_q, sp_d;
  logic [DEPTH-1:0] s_if, s_tf;

  always_comb begin
    sp_d = sp_q;
    if (push && !pop && sp_q != FULL)   sp_d = sp_q + 1'b1;
    else if (pop && !push && sp_q != 0) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic we;
    // plain push writes the free slot; push with pop replaces the top
    assign we = push && ((!pop && sp_q == PW'(i)) || (pop && sp_q == PW'(i + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_if[i] <= 1'b0;
        s_tf[i] <= 1'b0;
      end else if (we) begin
        s_if[i] <= in_if;
        s_tf[i] <= in_tf;
      end
    end
  end

  always_comb begin
    top_if = 1'b0;
    top_tf = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == PW'(i + 1)) begin
        top_if = s_if[i];
        top_tf = s_tf[i];
      end
    end
  end

  assign empty = (sp_q == '0);
endmodule

// File: rtl/intr_recog.sv
module intr_recog #(
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned NMI_MIN_LOW = 2,
  parameter int unsigned NEST_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic             intr_in,
  input  logic             boundary,
  input  logic             iret,
  input  logic             flag_ld,
  input  logic             ld_if,
  input  logic             ld_tf,
  input  logic [VEC_W-1:0] data_in,
  output logic             inta_n,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_type,
  output logic [VEC_W+1:0] vec_addr,
  output logic             if_q,
  output logic             tf_q
);
  import intr_pkg::*;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  seq_st_t          st_q, st_d;
  logic             if_r, tf_r, if_d, tf_d;
  logic             valid_q, valid_d;
  logic [VEC_W-1:0] type_q, type_d;
  logic             nmi_pend, top_if, top_tf, stk_empty;
  logic             cur_if, cur_tf, idle, restore;
  logic             take_step, take_nmi, take_intr, take;

  intr_nmi_qual #(.MIN_LOW(NMI_MIN_LOW)) u_nmi (
    .clk(clk), .rst_n(rst_sync), .nmi_in(nmi_in),
    .nmi_taken(take_nmi), .nmi_pend(nmi_pend)
  );

  intr_flag_stack #(.DEPTH(NEST_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_sync), .push(take), .pop(restore),
    .in_if(cur_if), .in_tf(cur_tf),
    .top_if(top_if), .top_tf(top_tf), .empty(stk_empty)
  );

  always_comb begin
    restore = iret && !stk_empty;
    if (restore) begin
      cur_if = top_if;
      cur_tf = top_tf;
    end else if (flag_ld) begin
      cur_if = ld_if;
      cur_tf = ld_tf;
    end else begin
      cur_if = if_r;
      cur_tf = tf_r;
    end
    idle      = (st_q == ST_IDLE);
    take_step = boundary && idle && cur_tf;
    take_nmi  = boundary && idle && !cur_tf && nmi_pend;
    take_intr = boundary && idle && !cur_tf && !nmi_pend && intr_in && cur_if;
    take      = take_step || take_nmi || take_intr;
    if_d      = take ? 1'b0 : cur_if;
    tf_d      = take ? 1'b0 : cur_tf;

    st_d    = st_q;
    valid_d = 1'b0;
    type_d  = type_q;
    case (st_q)
      ST_IDLE: begin
        if (take_intr) st_d = ST_ACK;
        if (take_step) begin
          valid_d = 1'b1;
          type_d  = VEC_W'(TYPE_STEP);
        end else if (take_nmi) begin
          valid_d = 1'b1;
          type_d  = VEC_W'(TYPE_NMI);
        end
      end
      ST_ACK: begin
        st_d    = ST_IDLE;
        valid_d = 1'b1;
        type_d  = data_in;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q    <= ST_IDLE;
      if_r    <= 1'b0;
      tf_r    <= 1'b0;
      valid_q <= 1'b0;
      type_q  <= '0;
    end else begin
      st_q    <= st_d;
      if_r    <= if_d;
      tf_r    <= tf_d;
      valid_q <= valid_d;
      type_q  <= type_d;
    end
  end

  assign inta_n    = (st_q != ST_ACK);
  assign vec_valid = valid_q;
  assign vec_type  = type_q;
  assign vec_addr  = {type_q, 2'b00};
  assign if_q      = if_r;
  assign tf_q      = tf_r;
endmodule

// File: rtl/intr_recog_chk.sv
module intr_recog_chk #(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary,
  input logic             iret,
  input logic             flag_ld,
  input logic             inta_n,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_type,
  input logic [VEC_W+1:0] vec_addr,
  input logic             if_q,
  input logic             tf_q
);
  assert_inta_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |=> inta_n);

  assert_vec_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |=> vec_valid);

  assert_flags_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> (!if_q && !tf_q));

  assert_intr_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && inta_n && !if_q && !iret && !flag_ld) |=> inta_n);

  assert_internal_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(inta_n)) |-> (vec_type == VEC_W'(1) || vec_type == VEC_W'(2)));

  assert_addr_scaled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[VEC_W+1:2] == vec_type && vec_addr[1:0] == 2'b00));
endmodule

bind intr_recog intr_recog_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .iret(iret),
  .flag_ld(flag_ld), .inta_n(inta_n), .vec_valid(vec_valid),
  .vec_type(vec_type), .vec_addr(vec_addr), .if_q(if_q), .tf_q(tf_q)
);

// File: tb/intr_recog_tb.sv
module intr_recog_tb_top;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 1'b0, intr_in = 1'b0, boundary = 1'b0, iret = 1'b0;
  logic flag_ld = 1'b0, ld_if = 1'b0, ld_tf = 1'b0;
  logic [VW-1:0] data_in = '0;
  logic inta_n, vec_valid, if_q, tf_q;
  logic [VW-1:0] vec_type;
  logic [VW+1:0] vec_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [VW-1:0] exp_q[$];

  always #5 clk = ~clk;

  intr_recog dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .intr_in(intr_in),
    .boundary(boundary), .iret(iret), .flag_ld(flag_ld), .ld_if(ld_if),
    .ld_tf(ld_tf), .data_in(data_in), .inta_n(inta_n), .vec_valid(vec_valid),
    .vec_type(vec_type), .vec_addr(vec_addr), .if_q(if_q), .tf_q(tf_q)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_flags(input logic i, input logic t);
    flag_ld = 1'b1; ld_if = i; ld_tf = t;
    tick();
    flag_ld = 1'b0;
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1;
    tick();
    boundary = 1'b0;
  endtask

  task automatic pulse_iret();
    iret = 1'b1;
    tick();
    iret = 1'b0;
  endtask

  task automatic expect_vec(input logic [VW-1:0] t);
    exp_q.push_back(t);
  endtask

  task automatic quiet(input string req);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(inta_n == 1'b1, req, "inta_n idle", int'(inta_n), 1);
    end
  endtask

  // monitor: pops the scoreboard on each result (R6 R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected vec_type", int'(vec_type), 0);
      end else begin
        logic [VW-1:0] e;
        e = exp_q.pop_front();
        check(vec_type == e, "R6/R7/R8", "vec_type", int'(vec_type), int'(e));
        check(vec_addr == {e, 2'b00}, "R10", "vec_addr", int'(vec_addr), int'({e, 2'b00}));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1
    check(inta_n == 1'b1, "R1", "inta_n", int'(inta_n), 1);
    check(vec_valid == 1'b0, "R1", "vec_valid", int'(vec_valid), 0);
    check(if_q == 1'b0 && tf_q == 1'b0, "R1", "flags", int'({if_q, tf_q}), 0);

    // R2
    load_flags(1'b1, 1'b0);
    check(if_q == 1'b1 && tf_q == 1'b0, "R2", "flags", int'({if_q, tf_q}), 2);

    // R9: request with enable clear
    load_flags(1'b0, 1'b0);
    intr_in = 1'b1; data_in = 8'h35;
    pulse_boundary();
    check(inta_n == 1'b1, "R9", "inta_n masked", int'(inta_n), 1);
    quiet("R9");

    // R8: maskable acknowledge
    load_flags(1'b1, 1'b0);
    expect_vec(8'h35);
    pulse_boundary();
    check(inta_n == 1'b0, "R8", "inta_n low", int'(inta_n), 0);
    tick();
    check(inta_n == 1'b1, "R8", "inta_n high", int'(inta_n), 1);
    check(if_q == 1'b0, "R11", "if cleared", int'(if_q), 0);
    intr_in = 1'b0;
    pulse_iret();
    check(if_q == 1'b1, "R11", "if restored", int'(if_q), 1);

    // R6: single step
    load_flags(1'b1, 1'b1);
    expect_vec(8'd1);
    pulse_boundary();
    check(tf_q == 1'b0, "R11", "tf cleared", int'(tf_q), 0);
    pulse_iret();
    check(tf_q == 1'b1, "R11", "tf restored", int'(tf_q), 1);

    // R7/R3: long low then rising edge
    load_flags(1'b0, 1'b0);
    nmi_in = 1'b1;
    tick(); tick();
    expect_vec(8'd2);
    pulse_boundary();
    tick();
    nmi_in = 1'b0;
    pulse_iret();

    // R4: accepted edge dropped before recognition
    tick(); tick();
    nmi_in = 1'b1;
    tick(); tick();
    nmi_in = 1'b0;
    tick();
    pulse_boundary();
    check(vec_valid == 1'b0, "R4", "dropped nmi", int'(vec_valid), 0);
    tick();
    check(vec_valid == 1'b0, "R4", "dropped nmi", int'(vec_valid), 0);

    // R3: one low clock is too short
    nmi_in = 1'b1; tick();
    nmi_in = 1'b0; tick();
    nmi_in = 1'b1; tick(); tick();
    pulse_boundary();
    check(vec_valid == 1'b0, "R3", "short low rejected", int'(vec_valid), 0);
    tick();
    check(vec_valid == 1'b0, "R3", "short low rejected", int'(vec_valid), 0);
    // R3: exactly two low clocks is enough
    nmi_in = 1'b0; tick(); tick();
    nmi_in = 1'b1; tick(); tick();
    expect_vec(8'd2);
    pulse_boundary();
    tick();
    nmi_in = 1'b0;
    pulse_iret();

    // R5: all three sources at once
    tick(); tick();
    load_flags(1'b1, 1'b1);
    nmi_in = 1'b1; intr_in = 1'b1; data_in = 8'h80;
    tick(); tick();
    expect_vec(8'd1);
    pulse_boundary();
    check(if_q == 1'b0 && tf_q == 1'b0, "R5", "flags after step", int'({if_q, tf_q}), 0);
    expect_vec(8'd2);
    pulse_boundary();
    nmi_in = 1'b0;
    pulse_boundary();
    check(inta_n == 1'b1, "R5", "intr blocked in handler", int'(inta_n), 1);
    pulse_iret();
    check(if_q == 1'b0 && tf_q == 1'b0, "R11", "inner pop", int'({if_q, tf_q}), 0);
    pulse_iret();
    check(if_q == 1'b1 && tf_q == 1'b1, "R11", "outer pop", int'({if_q, tf_q}), 3);
    load_flags(1'b1, 1'b0);
    expect_vec(8'h80);
    pulse_boundary();
    check(inta_n == 1'b0, "R5", "intr last", int'(inta_n), 0);
    tick();

    // R12: return and boundary together inside the handler
    data_in = 8'h5A;
    expect_vec(8'h5A);
    iret = 1'b1; boundary = 1'b1;
    tick();
    iret = 1'b0; boundary = 1'b0;
    check(inta_n == 1'b0, "R12", "restored enable takes intr", int'(inta_n), 0);
    tick();
    check(if_q == 1'b0, "R12", "if cleared", int'(if_q), 0);
    pulse_iret();
    check(if_q == 1'b1 && tf_q == 1'b0, "R12", "saved pair", int'({if_q, tf_q}), 2);
    pulse_iret();
    check(if_q == 1'b1 && tf_q == 1'b0, "R11", "empty iret", int'({if_q, tf_q}), 2);

    // R13: boundary during the acknowledge cycle
    data_in = 8'h77;
    expect_vec(8'h77);
    boundary = 1'b1;
    tick();
    check(inta_n == 1'b0, "R13", "ack started", int'(inta_n), 0);
    flag_ld = 1'b1; ld_if = 1'b1; ld_tf = 1'b0;
    tick();
    boundary = 1'b0; flag_ld = 1'b0; intr_in = 1'b0;
    check(inta_n == 1'b1, "R13", "no second ack", int'(inta_n), 1);
    check(if_q == 1'b1, "R2", "load during ack", int'(if_q), 1);
    quiet("R13");

    tick();
    check(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule